// File: doc/BRIEF.md
# Legacy PC Memory Address Router

This block sits between a processor's physical address path and the storage behind it. For every access it works out which target serves that access: main RAM, the video memory port, the system firmware ROM, the expansion ROM, or nothing at all. It also gives the byte offset into that target. The inputs are a byte address, a read/write flag, a code-fetch flag and the processor's system-management-mode flag. The routing decision is combinational, so it is valid in the same cycle as the request.

The block holds the three-bit system-management RAM control state: available, open and locked. Two control operations change it. Open sets available and loads the open and lock bits. Close clears all three bits. The 128 KiB video window can be overlaid with RAM, depending on this state, the mode flag and whether the access is a fetch or data. The 256 KiB legacy upper area can be switched to shadow RAM. When shadowing is on, the area is split into equal regions, and each region carries a two-bit type code for reads and another for writes. ROM contents are never written. Reads that hit no target ask for an all-ones fill and raise a fault.

Top module: `legacy_mem_router`

## Requirements
- R1: A data access in 0xA0000–0xBFFFF goes to RAM with offset equal to the address when the open bit is set or smm is high. Otherwise it goes to the video port with offset address[16:0].
- R2: A code fetch in 0xA0000–0xBFFFF goes to RAM only when available is set and either open is set or smm is high. Otherwise it goes to the video port.
- R3: smram_data_ok is high exactly when available is set and either open is set or lock is clear.
- R4: Reset clears available, open and lock. An open op loads available=1 and the given open and lock bits, visible from the next cycle. A close op clears all three bits, visible from the next cycle. Close wins when both ops arrive in the same cycle.
- R5: With shadowing off, a read in 0xE0000–0xFFFFF goes to the firmware ROM at offset address & 0x1FFFF. A read in 0xC0000–0xDFFFF goes to the expansion ROM at offset (address & 0x1FFFF) + 0x20000. A write anywhere in 0xC0000–0xFFFFF is dropped: target none, ok=0, fault=0.
- R6: With shadowing on, an access in 0xC0000–0xFFFFF picks its region by address[17:14]. Region i's code is bits [2i+1:2i] of the read vector for reads and of the write vector for writes. A read with code 0 follows the ROM mapping of R5. Code 1 goes to RAM at offset equal to the address. Codes 2 and 3 give target none with fault=1.
- R7: With shadowing on, a write with code 0 is dropped (ok=0, fault=0), and a write with code 1 goes to RAM. No write ever targets a ROM or raises the all-ones fill.
- R8: A read at or above 0xFFFE0000 goes to the firmware ROM at offset address & 0x1FFFF. A write there gives target none with fault=1.
- R9: Any other address at or above the RAM size of RAM_MB MiB gives target none with fault=1. A read there also raises route_ones.
- R10: Any other address below RAM_MB MiB goes to RAM with offset equal to the address and ok=1.
- R11: route_target encodes RAM=0, video=1, firmware ROM=2, expansion ROM=3 and none=4. It follows the request inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control state |
| rst_n | input | 1 | Asynchronous active-low reset |
| smram_open_op | input | 1 | Open operation: sets available and loads the open and lock bits |
| smram_close_op | input | 1 | Close operation: clears all control bits |
| smram_open_val | input | 1 | Open bit loaded by an open op |
| smram_lock_val | input | 1 | Lock bit loaded by an open op |
| shadow_on | input | 1 | Enables per-region type lookup in 0xC0000–0xFFFFF |
| shadow_rd_types | input | 2*SHADOW_REGIONS | Read type code per region |
| shadow_wr_types | input | 2*SHADOW_REGIONS | Write type code per region |
| acc_addr | input | ADDR_W | Physical byte address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_code | input | 1 | 1 for an instruction fetch |
| cpu_smm | input | 1 | Processor is in system-management mode |
| route_target | output | 3 | Selected target code |
| route_offset | output | ADDR_W | Byte offset into the target |
| route_ok | output | 1 | The access is carried out at the target |
| route_fault | output | 1 | The access is in error |
| route_ones | output | 1 | Read data must be forced to all ones |
| smram_data_ok | output | 1 | Data accesses may use system-management RAM |

## Verification
Video-window accesses are tried with every useful combination of control state, mode flag and fetch/data kind. The case of smm high with available clear is the one that separates the fetch rule from the data rule. Legacy-area accesses are made with shadowing off and then with regions set to each of the four codes, once for reads and once for writes. This shows that each access kind selects its own vector, and that region indexing and the expansion-ROM offset base are correct. Addresses just inside and just outside the RAM top, and inside the high firmware alias, separate the RAM, alias and void paths for both reads and writes.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    typedef enum logic [2:0] {
        TGT_RAM  = 3'd0,
        TGT_VGA  = 3'd1,
        TGT_BIOS = 3'd2,
        TGT_XROM = 3'd3,
        TGT_NONE = 3'd4
    } lmr_target_e;

    typedef enum logic [2:0] {
        WIN_VIDEO  = 3'd0,
        WIN_LEGACY = 3'd1,
        WIN_RAM    = 3'd2,
        WIN_ALIAS  = 3'd3,
        WIN_VOID   = 3'd4
    } lmr_window_e;

    typedef struct packed {
        logic avail;
        logic open;
        logic lock;
    } lmr_smram_t;

    localparam logic [1:0] TYPE_ROM    = 2'd0;
    localparam logic [1:0] TYPE_SHADOW = 2'd1;

endpackage

// File: rtl/lmr_smram_ctrl.sv
module lmr_smram_ctrl
    import lmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_open,
    input  logic       op_close,
    input  logic       set_open,
    input  logic       set_lock,
    output lmr_smram_t state_q,
    output logic       data_ok
);

    typedef struct packed {
        lmr_smram_t st;
    } ctrl_state_t;

    ctrl_state_t cur_q;
    ctrl_state_t cur_d;

    always_comb begin
        cur_d = cur_q;
        if (op_close) begin
            cur_d.st = '0;
        end else if (op_open) begin
            cur_d.st.avail = 1'b1;
            cur_d.st.open  = set_open;
            cur_d.st.lock  = set_lock;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign state_q = cur_q.st;
    assign data_ok = cur_q.st.avail & (cur_q.st.open | ~cur_q.st.lock);

endmodule

// File: rtl/lmr_window_decode.sv
module lmr_window_decode
    import lmr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RAM_MB     = 16,
    parameter int BIOS_BYTES = 131072
) (
    input  logic [ADDR_W-1:0] addr,
    output lmr_window_e       window,
    output logic              upper_rom
);

    localparam int BIOS_BITS = $clog2(BIOS_BYTES);
    localparam logic [ADDR_W:0] RAM_TOP = (ADDR_W+1)'(RAM_MB) << 20;
    localparam logic [ADDR_W-18:0] VIDEO_TAG  = (ADDR_W-17)'(5);
    localparam logic [ADDR_W-19:0] LEGACY_TAG = (ADDR_W-18)'(3);

    logic in_video;
    logic in_legacy;
    logic in_ram;
    logic in_alias;

    always_comb begin
        in_video  = (addr[ADDR_W-1:17] == VIDEO_TAG);
        in_legacy = (addr[ADDR_W-1:18] == LEGACY_TAG);
        in_ram    = ({1'b0, addr} < RAM_TOP);
        in_alias  = &addr[ADDR_W-1:BIOS_BITS];
        upper_rom = addr[17];

        if (in_video) begin
            window = WIN_VIDEO;
        end else if (in_legacy) begin
            window = WIN_LEGACY;
        end else if (in_ram) begin
            window = WIN_RAM;
        end else if (in_alias) begin
            window = WIN_ALIAS;
        end else begin
            window = WIN_VOID;
        end
    end

endmodule

// File: rtl/lmr_shadow_lookup.sv
module lmr_shadow_lookup #(
    parameter int REGIONS = 16
) (
    input  logic [17:0]          addr_lo,
    input  logic [2*REGIONS-1:0] rd_types,
    input  logic [2*REGIONS-1:0] wr_types,
    input  logic                 is_write,
    output logic [1:0]           type_code
);

    localparam int SEL_BITS = $clog2(REGIONS);

    logic [1:0] rd_code [REGIONS];
    logic [1:0] wr_code [REGIONS];
    logic [SEL_BITS-1:0] sel;

    for (genvar g = 0; g < REGIONS; g++) begin : g_region
        assign rd_code[g] = rd_types[2*g +: 2];
        assign wr_code[g] = wr_types[2*g +: 2];
    end

    always_comb begin
        sel       = addr_lo[17 -: SEL_BITS];
        type_code = is_write ? wr_code[sel] : rd_code[sel];
    end

endmodule

// File: rtl/lmr_route_select.sv
module lmr_route_select
    import lmr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BIOS_BYTES = 131072,
    parameter int XROM_BYTES = 131072
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              is_code,
    input  logic              smm,
    input  lmr_smram_t        smram,
    input  lmr_window_e       window,
    input  logic              upper_rom,
    input  logic              shadow_on,
    input  logic [1:0]        type_code,
    output lmr_target_e       target,
    output logic [ADDR_W-1:0] offset,
    output logic              ok,
    output logic              fault,
    output logic              ones
);

    localparam logic [ADDR_W-1:0] BIOS_MASK  = ADDR_W'(BIOS_BYTES - 1);
    localparam logic [ADDR_W-1:0] XROM_MASK  = ADDR_W'(XROM_BYTES - 1);
    localparam logic [ADDR_W-1:0] XROM_BASE  = ADDR_W'(BIOS_BYTES);
    localparam logic [ADDR_W-1:0] VIDEO_MASK = ADDR_W'(32'h1FFFF);

    logic        video_ram;
    lmr_target_e rom_tgt;
    logic [ADDR_W-1:0] rom_off;

    always_comb begin
        if (is_code) begin
            video_ram = smram.avail & (smram.open | smm);
        end else begin
            video_ram = smram.open | smm;
        end

        if (upper_rom) begin
            rom_tgt = TGT_BIOS;
            rom_off = addr & BIOS_MASK;
        end else begin
            rom_tgt = TGT_XROM;
            rom_off = (addr & XROM_MASK) + XROM_BASE;
        end
    end

    always_comb begin
        target = TGT_NONE;
        offset = '0;
        ok     = 1'b0;
        fault  = 1'b0;
        ones   = 1'b0;
        unique case (window)
            WIN_VIDEO: begin
                ok = 1'b1;
                if (video_ram) begin
                    target = TGT_RAM;
                    offset = addr;
                end else begin
                    target = TGT_VGA;
                    offset = addr & VIDEO_MASK;
                end
            end
            WIN_LEGACY: begin
                if (shadow_on) begin
                    if (type_code == TYPE_ROM) begin
                        if (!is_write) begin
                            target = rom_tgt;
                            offset = rom_off;
                            ok     = 1'b1;
                        end
                    end else if (type_code == TYPE_SHADOW) begin
                        target = TGT_RAM;
                        offset = addr;
                        ok     = 1'b1;
                    end else begin
                        fault = 1'b1;
                    end
                end else if (!is_write) begin
                    target = rom_tgt;
                    offset = rom_off;
                    ok     = 1'b1;
                end
            end
            WIN_RAM: begin
                target = TGT_RAM;
                offset = addr;
                ok     = 1'b1;
            end
            WIN_ALIAS: begin
                if (is_write) begin
                    fault = 1'b1;
                end else begin
                    target = TGT_BIOS;
                    offset = addr & BIOS_MASK;
                    ok     = 1'b1;
                end
            end
            default: begin
                fault = 1'b1;
                ones  = ~is_write;
            end
        endcase
    end

endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
    import lmr_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int RAM_MB         = 16,
    parameter int BIOS_BYTES     = 131072,
    parameter int XROM_BYTES     = 131072,
    parameter int SHADOW_REGIONS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smram_open_op,
    input  logic                        smram_close_op,
    input  logic                        smram_open_val,
    input  logic                        smram_lock_val,
    input  logic                        shadow_on,
    input  logic [2*SHADOW_REGIONS-1:0] shadow_rd_types,
    input  logic [2*SHADOW_REGIONS-1:0] shadow_wr_types,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic                        acc_write,
    input  logic                        acc_code,
    input  logic                        cpu_smm,
    output logic [2:0]                  route_target,
    output logic [ADDR_W-1:0]           route_offset,
    output logic                        route_ok,
    output logic                        route_fault,
    output logic                        route_ones,
    output logic                        smram_data_ok
);

    lmr_smram_t  smram_st;
    lmr_window_e window;
    logic        upper_rom;
    logic [1:0]  type_code;
    lmr_target_e target;

    lmr_smram_ctrl u_smram (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_open  (smram_open_op),
        .op_close (smram_close_op),
        .set_open (smram_open_val),
        .set_lock (smram_lock_val),
        .state_q  (smram_st),
        .data_ok  (smram_data_ok)
    );

    lmr_window_decode #(
        .ADDR_W     (ADDR_W),
        .RAM_MB     (RAM_MB),
        .BIOS_BYTES (BIOS_BYTES)
    ) u_window (
        .addr      (acc_addr),
        .window    (window),
        .upper_rom (upper_rom)
    );

    lmr_shadow_lookup #(
        .REGIONS (SHADOW_REGIONS)
    ) u_shadow (
        .addr_lo   (acc_addr[17:0]),
        .rd_types  (shadow_rd_types),
        .wr_types  (shadow_wr_types),
        .is_write  (acc_write),
        .type_code (type_code)
    );

    lmr_route_select #(
        .ADDR_W     (ADDR_W),
        .BIOS_BYTES (BIOS_BYTES),
        .XROM_BYTES (XROM_BYTES)
    ) u_select (
        .addr      (acc_addr),
        .is_write  (acc_write),
        .is_code   (acc_code),
        .smm       (cpu_smm),
        .smram     (smram_st),
        .window    (window),
        .upper_rom (upper_rom),
        .shadow_on (shadow_on),
        .type_code (type_code),
        .target    (target),
        .offset    (route_offset),
        .ok        (route_ok),
        .fault     (route_fault),
        .ones      (route_ones)
    );

    assign route_target = target;

endmodule

// File: rtl/lmr_router_checker.sv
module lmr_router_checker
    import lmr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RAM_MB = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smram_open_op,
    input logic              smram_close_op,
    input logic              smram_open_val,
    input logic              smram_lock_val,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              acc_code,
    input logic              cpu_smm,
    input lmr_smram_t        smram_st,
    input logic [2:0]        route_target,
    input logic [ADDR_W-1:0] route_offset,
    input logic              route_fault,
    input logic              route_ones,
    input logic              smram_data_ok
);

    localparam logic [ADDR_W:0] RAM_TOP = (ADDR_W+1)'(RAM_MB) << 20;

    logic video_hit;
    assign video_hit = (acc_addr[ADDR_W-1:17] == (ADDR_W-17)'(5));

    p_close_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smram_close_op |=> (smram_st == '0));

    p_open_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smram_open_op && !smram_close_op) |=>
            (smram_st.avail && smram_st.open == $past(smram_open_val)
             && smram_st.lock == $past(smram_lock_val)));

    p_unavail_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smram_st.avail |-> !smram_data_ok);

    p_video_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (video_hit && !acc_code && !smram_st.open && !cpu_smm) |->
            (route_target == 3'd1));

    p_fetch_needs_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (video_hit && acc_code && !smram_st.avail) |-> (route_target == 3'd1));

    p_no_rom_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_write |-> (route_target != 3'd2 && route_target != 3'd3 && !route_ones));

    p_ones_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        route_ones |-> (route_fault && route_target == 3'd4));

    p_ram_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (route_target == 3'd0) |-> ({1'b0, route_offset} < RAM_TOP));

    p_target_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        route_target <= 3'd4);

endmodule

bind legacy_mem_router lmr_router_checker #(
    .ADDR_W (ADDR_W),
    .RAM_MB (RAM_MB)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .smram_open_op  (smram_open_op),
    .smram_close_op (smram_close_op),
    .smram_open_val (smram_open_val),
    .smram_lock_val (smram_lock_val),
    .acc_addr       (acc_addr),
    .acc_write      (acc_write),
    .acc_code       (acc_code),
    .cpu_smm        (cpu_smm),
    .smram_st       (smram_st),
    .route_target   (route_target),
    .route_offset   (route_offset),
    .route_fault    (route_fault),
    .route_ones     (route_ones),
    .smram_data_ok  (smram_data_ok)
);

// File: tb/legacy_mem_router_test.sv
module legacy_mem_router_test;

    localparam int AW = 32;
    localparam int NR = 16;

    localparam logic [2:0] T_RAM  = 3'd0;
    localparam logic [2:0] T_VGA  = 3'd1;
    localparam logic [2:0] T_BIOS = 3'd2;
    localparam logic [2:0] T_XROM = 3'd3;
    localparam logic [2:0] T_NONE = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smram_open_op = 1'b0;
    logic          smram_close_op = 1'b0;
    logic          smram_open_val = 1'b0;
    logic          smram_lock_val = 1'b0;
    logic          shadow_on = 1'b0;
    logic [2*NR-1:0] shadow_rd_types = '0;
    logic [2*NR-1:0] shadow_wr_types = '0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_write = 1'b0;
    logic          acc_code = 1'b0;
    logic          cpu_smm = 1'b0;
    logic [2:0]    route_target;
    logic [AW-1:0] route_offset;
    logic          route_ok;
    logic          route_fault;
    logic          route_ones;
    logic          smram_data_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    legacy_mem_router uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .smram_open_op   (smram_open_op),
        .smram_close_op  (smram_close_op),
        .smram_open_val  (smram_open_val),
        .smram_lock_val  (smram_lock_val),
        .shadow_on       (shadow_on),
        .shadow_rd_types (shadow_rd_types),
        .shadow_wr_types (shadow_wr_types),
        .acc_addr        (acc_addr),
        .acc_write       (acc_write),
        .acc_code        (acc_code),
        .cpu_smm         (cpu_smm),
        .route_target    (route_target),
        .route_offset    (route_offset),
        .route_ok        (route_ok),
        .route_fault     (route_fault),
        .route_ones      (route_ones),
        .smram_data_ok   (smram_data_ok)
    );

    task automatic route_chk(input string req, input logic [AW-1:0] a, input logic wr,
                             input logic cd, input logic smm, input logic [2:0] et,
                             input logic [AW-1:0] eo, input logic eok, input logic ef,
                             input logic e1);
        @(negedge clk);
        acc_addr = a; acc_write = wr; acc_code = cd; cpu_smm = smm;
        #2;
        checks++;
        if (route_target !== et || route_offset !== eo || route_ok !== eok ||
            route_fault !== ef || route_ones !== e1) begin
            errors++;
            $display("FAIL %s addr=%h wr=%0b code=%0b smm=%0b: got tgt=%0d off=%h ok=%0b fault=%0b ones=%0b, expected tgt=%0d off=%h ok=%0b fault=%0b ones=%0b",
                     req, a, wr, cd, smm, route_target, route_offset, route_ok,
                     route_fault, route_ones, et, eo, eok, ef, e1);
        end
    endtask

    task automatic dataok_chk(input string req, input logic exp);
        #2;
        checks++;
        if (smram_data_ok !== exp) begin
            errors++;
            $display("FAIL %s smram_data_ok got %0b expected %0b", req, smram_data_ok, exp);
        end
    endtask

    task automatic smram_op(input logic op, input logic cl, input logic ov, input logic lv);
        @(negedge clk);
        smram_open_op = op; smram_close_op = cl; smram_open_val = ov; smram_lock_val = lv;
        @(negedge clk);
        smram_open_op = 1'b0; smram_close_op = 1'b0;
    endtask

    task automatic test_reset();
        dataok_chk("R4 reset clears control", 1'b0);
        route_chk("R1 reset video data", 32'h000A_0010, 0, 0, 0, T_VGA, 32'h10, 1, 0, 0);
        route_chk("R2 reset video fetch smm", 32'h000A_0010, 0, 1, 1, T_VGA, 32'h10, 1, 0, 0);
    endtask

    task automatic test_plain_ram();
        route_chk("R10 low read", 32'h0000_1234, 0, 0, 0, T_RAM, 32'h1234, 1, 0, 0);
        route_chk("R10 last byte write", 32'h00FF_FFFF, 1, 0, 0, T_RAM, 32'h00FF_FFFF, 1, 0, 0);
        route_chk("R10 above 1MiB fetch", 32'h0010_0000, 0, 1, 0, T_RAM, 32'h0010_0000, 1, 0, 0);
        route_chk("R9 read past top", 32'h0100_0000, 0, 0, 0, T_NONE, 32'h0, 0, 1, 1);
        route_chk("R9 write past top", 32'h0100_0000, 1, 0, 0, T_NONE, 32'h0, 0, 1, 0);
        route_chk("R9 read below alias", 32'hFFFD_FFFF, 0, 0, 0, T_NONE, 32'h0, 0, 1, 1);
    endtask

    task automatic test_alias();
        route_chk("R8 alias read", 32'hFFFF_FFF0, 0, 1, 0, T_BIOS, 32'h1FFF0, 1, 0, 0);
        route_chk("R8 alias base read", 32'hFFFE_0000, 0, 0, 0, T_BIOS, 32'h0, 1, 0, 0);
        route_chk("R8 alias write", 32'hFFFF_FFF0, 1, 0, 0, T_NONE, 32'h0, 0, 1, 0);
    endtask

    task automatic test_no_shadow();
        shadow_on = 1'b0;
        route_chk("R5 upper rom read", 32'h000F_0010, 0, 0, 0, T_BIOS, 32'h10010, 1, 0, 0);
        route_chk("R5 lower firmware read", 32'h000E_0000, 0, 1, 0, T_BIOS, 32'h0, 1, 0, 0);
        route_chk("R5 expansion read", 32'h000C_8000, 0, 0, 0, T_XROM, 32'h28000, 1, 0, 0);
        route_chk("R5 rom write dropped", 32'h000C_8000, 1, 0, 0, T_NONE, 32'h0, 0, 0, 0);
        route_chk("R5 firmware write dropped", 32'h000F_FFFF, 1, 0, 0, T_NONE, 32'h0, 0, 0, 0);
    endtask

    task automatic test_shadow();
        shadow_on = 1'b1;
        shadow_rd_types = '0;
        shadow_wr_types = '0;
        shadow_rd_types[2*2 +: 2]  = 2'd1;
        shadow_wr_types[2*2 +: 2]  = 2'd0;
        shadow_rd_types[2*9 +: 2]  = 2'd0;
        shadow_wr_types[2*9 +: 2]  = 2'd1;
        shadow_rd_types[2*14 +: 2] = 2'd2;
        shadow_wr_types[2*14 +: 2] = 2'd3;
        route_chk("R6 region2 read shadow", 32'h000C_8000, 0, 0, 0, T_RAM, 32'h000C_8000, 1, 0, 0);
        route_chk("R7 region2 write rom dropped", 32'h000C_8004, 1, 0, 0, T_NONE, 32'h0, 0, 0, 0);
        route_chk("R6 region9 read rom", 32'h000E_4000, 0, 0, 0, T_BIOS, 32'h4000, 1, 0, 0);
        route_chk("R7 region9 write shadow", 32'h000E_4000, 1, 0, 0, T_RAM, 32'h000E_4000, 1, 0, 0);
        route_chk("R6 region14 read bad code", 32'h000F_8000, 0, 0, 0, T_NONE, 32'h0, 0, 1, 0);
        route_chk("R6 region14 write bad code", 32'h000F_8000, 1, 0, 0, T_NONE, 32'h0, 0, 1, 0);
        route_chk("R6 region0 read rom expansion", 32'h000C_0100, 0, 0, 0, T_XROM, 32'h20100, 1, 0, 0);
        shadow_on = 1'b0;
        route_chk("R5 shadow off ignores codes", 32'h000C_8000, 0, 0, 0, T_XROM, 32'h28000, 1, 0, 0);
    endtask

    task automatic test_smram();
        smram_op(1, 0, 1, 0);
        dataok_chk("R3 open unlocked", 1'b1);
        route_chk("R1 open data", 32'h000A_0010, 0, 0, 0, T_RAM, 32'h000A_0010, 1, 0, 0);
        route_chk("R2 open fetch", 32'h000B_FFFF, 0, 1, 0, T_RAM, 32'h000B_FFFF, 1, 0, 0);
        smram_op(1, 0, 0, 1);
        dataok_chk("R3 closed locked", 1'b0);
        route_chk("R1 locked data no smm", 32'h000A_0010, 0, 0, 0, T_VGA, 32'h10, 1, 0, 0);
        route_chk("R2 locked fetch smm", 32'h000A_0010, 0, 1, 1, T_RAM, 32'h000A_0010, 1, 0, 0);
        route_chk("R1 locked data smm", 32'h000A_0010, 1, 0, 1, T_RAM, 32'h000A_0010, 1, 0, 0);
        smram_op(1, 0, 0, 0);
        dataok_chk("R3 available unlocked", 1'b1);
        route_chk("R2 avail fetch no smm", 32'h000A_0010, 0, 1, 0, T_VGA, 32'h10, 1, 0, 0);
        smram_op(0, 1, 0, 0);
        dataok_chk("R4 close clears", 1'b0);
        route_chk("R2 closed fetch smm", 32'h000A_0010, 0, 1, 1, T_VGA, 32'h10, 1, 0, 0);
        route_chk("R1 closed data smm", 32'h000A_0010, 0, 0, 1, T_RAM, 32'h000A_0010, 1, 0, 0);
        smram_op(1, 1, 1, 0);
        dataok_chk("R4 close wins", 1'b0);
        route_chk("R4 close wins route", 32'h000A_0010, 0, 0, 0, T_VGA, 32'h10, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_plain_ram();
        test_alias();
        test_no_shadow();
        test_shadow();
        test_smram();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired: got hang, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule